// File: doc/BRIEF.md
# Video Line Format Sequencer

This block tells the output packer, one video line at a time, how each scaled line leaves the chip. A line leaves either as luma only or as luma plus chroma. A programmable cadence sets how many luma-only lines come before each luma/chroma line. That lets a 4:2:2 internal stream be sent out as 4:2:0 or 4:1:0 style vertical subsampling. The block also passes the horizontal packing choice through to the packer, after cleaning it. Formats are laid out in 32-bit words, and only interleaved (non-planar) layouts exist.

The field logic pulses `sof_i` once at the start of each field and `eol_i` at the end of each line. At start of field the block captures the cadence, the lead-keep bit and the packing select. It then holds them fixed until the next start of field. The block flags each line as luma-only or luma/chroma. It can also mark a line for dropping, so that a field may be made to open on a luma/chroma line.

Top module: `line_fmt_seq`

## Requirements
- R1: While `rst_ni` is low, and until the first `sof_i`, the outputs are `line_yc_o`=1, `line_drop_o`=0 and `pack_mode_o`=0.
- R2: `cadence_i`, `keep_lead_i` and `pack_sel_i` are captured only on a cycle with `sof_i`=1. A change on any other cycle has no effect until the next `sof_i`.
- R3: Every `sof_i` restarts the line cadence at its first position and clears the record that a luma/chroma line has been seen. This holds even if the cadence was partway through.
- R4: With a captured cadence N, the lines of a field run as N luma-only lines (`line_yc_o`=0) and then one luma/chroma line (`line_yc_o`=1), repeating. Each `eol_i` moves to the next line.
- R5: A captured cadence of 0 makes every line a luma/chroma line.
- R6: With `keep_lead_i`=0 captured, the luma-only lines before the first luma/chroma line of the field have `line_drop_o`=1.
- R7: With `keep_lead_i`=1 captured, the leading luma-only lines have `line_drop_o`=0.
- R8: Once the first luma/chroma line of a field has ended, `line_drop_o` stays 0 for the rest of the field.
- R9: Packing select 4 (luma only) forces `line_yc_o`=0 and `line_drop_o`=0 on every line, whatever the cadence is.
- R10: Packing select codes are 0=4:2:2, 1=4:1:1, 2=4:2:0, 3=4:1:0 and 4=luma only, and `pack_mode_o` carries the captured code. The reserved codes 5 to 7 are captured as 0.
- R11: When `sof_i` and `eol_i` arrive in the same cycle, `sof_i` takes effect and `eol_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-field pulse |
| eol_i | input | 1 | End-of-line pulse |
| cadence_i | input | 2 | Number of luma-only lines before each luma/chroma line |
| keep_lead_i | input | 1 | 1: output the leading luma-only lines; 0: drop them |
| pack_sel_i | input | 3 | Horizontal packing select |
| line_yc_o | output | 1 | Current line carries luma and chroma |
| line_drop_o | output | 1 | Current line is to be discarded |
| pack_mode_o | output | 3 | Captured packing code for the current field |

## Verification
The assertions check the invariants on every cycle. The outputs hold steady when no pulse arrives. The packing code changes only at start of field. A dropped line is never a luma/chroma line. No drop follows a finished luma/chroma line. Luma-only mode and cadence 0 give the forced line types, and reserved codes are cleaned. Only the bench scenarios can show the full cadence sequence, the cadence restart partway through a field, the settings ignored mid-field, and `sof_i` winning over a same-cycle `eol_i`.

// File: rtl/line_fmt_pkg.sv
package line_fmt_pkg;

  localparam int unsigned PackW = 3;

  typedef enum logic [PackW-1:0] {
    PACK_422   = 3'd0,
    PACK_411   = 3'd1,
    PACK_420   = 3'd2,
    PACK_410   = 3'd3,
    PACK_YONLY = 3'd4
  } pack_e;

  // reserved codes fall back to 4:2:2
  function automatic pack_e clean_pack(logic [PackW-1:0] sel);
    pack_e res;
    case (sel)
      3'd1:    res = PACK_411;
      3'd2:    res = PACK_420;
      3'd3:    res = PACK_410;
      3'd4:    res = PACK_YONLY;
      default: res = PACK_422;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/lfs_cfg_latch.sv
module lfs_cfg_latch
  import line_fmt_pkg::*;
#(
  parameter int unsigned CadW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sof_i,
  input  logic [CadW-1:0] cadence_i,
  input  logic            keep_lead_i,
  input  logic [PackW-1:0] pack_sel_i,
  output logic [CadW-1:0] cadence_o,
  output logic            keep_lead_o,
  output pack_e           pack_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cadence_o   <= '0;
      keep_lead_o <= 1'b1;
      pack_o      <= PACK_422;
    end else if (sof_i) begin
      cadence_o   <= cadence_i;
      keep_lead_o <= keep_lead_i;
      pack_o      <= clean_pack(pack_sel_i);
    end
  end

endmodule

// File: rtl/lfs_cadence_ctr.sv
module lfs_cadence_ctr #(
  parameter int unsigned CadW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sof_i,
  input  logic            eol_i,
  input  logic [CadW-1:0] cadence_i,
  output logic            at_yc_o,
  output logic            seen_yc_o
);

  logic [CadW-1:0] pos_q;

  assign at_yc_o = (pos_q == cadence_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      seen_yc_o <= 1'b0;
    end else if (sof_i) begin
      pos_q     <= '0;
      seen_yc_o <= 1'b0;
    end else if (eol_i) begin
      if (at_yc_o) begin
        pos_q     <= '0;
        seen_yc_o <= 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lfs_line_class.sv
module lfs_line_class
  import line_fmt_pkg::*;
(
  input  pack_e pack_i,
  input  logic  keep_lead_i,
  input  logic  at_yc_i,
  input  logic  seen_yc_i,
  output logic  line_yc_o,
  output logic  line_drop_o
);

  logic yonly;

  assign yonly       = (pack_i == PACK_YONLY);
  assign line_yc_o   = !yonly && at_yc_i;
  // leading luma-only lines of a field, only when a Y/C line will follow
  assign line_drop_o = !yonly && !keep_lead_i && !seen_yc_i && !at_yc_i;

endmodule

// File: rtl/line_fmt_seq.sv
module line_fmt_seq
  import line_fmt_pkg::*;
#(
  parameter int unsigned CadW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sof_i,
  input  logic            eol_i,
  input  logic [CadW-1:0] cadence_i,
  input  logic            keep_lead_i,
  input  logic [2:0]      pack_sel_i,
  output logic            line_yc_o,
  output logic            line_drop_o,
  output logic [2:0]      pack_mode_o
);

  logic [CadW-1:0] cad_q;
  logic            keep_q;
  pack_e           pack_q;
  logic            at_yc, seen_yc;

  lfs_cfg_latch #(.CadW(CadW)) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .cadence_i   (cadence_i),
    .keep_lead_i (keep_lead_i),
    .pack_sel_i  (pack_sel_i),
    .cadence_o   (cad_q),
    .keep_lead_o (keep_q),
    .pack_o      (pack_q)
  );

  lfs_cadence_ctr #(.CadW(CadW)) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .eol_i     (eol_i),
    .cadence_i (cad_q),
    .at_yc_o   (at_yc),
    .seen_yc_o (seen_yc)
  );

  lfs_line_class i_cls (
    .pack_i      (pack_q),
    .keep_lead_i (keep_q),
    .at_yc_i     (at_yc),
    .seen_yc_i   (seen_yc),
    .line_yc_o   (line_yc_o),
    .line_drop_o (line_drop_o)
  );

  assign pack_mode_o = pack_q;

endmodule

// File: rtl/line_fmt_seq_chk.sv
module line_fmt_seq_chk #(
  parameter int unsigned CadW = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sof_i,
  input logic            eol_i,
  input logic [CadW-1:0] cadence_i,
  input logic            keep_lead_i,
  input logic [2:0]      pack_sel_i,
  input logic            line_yc_o,
  input logic            line_drop_o,
  input logic [2:0]      pack_mode_o
);

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> line_yc_o && !line_drop_o && pack_mode_o == 3'd0);

  assert_cfg_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(pack_mode_o));

  assert_line_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i && !eol_i |=> $stable(line_yc_o) && $stable(line_drop_o));

  assert_cad_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && cadence_i == '0 && pack_sel_i != 3'd4 |=> line_yc_o);

  assert_drop_not_yc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_drop_o |-> !line_yc_o);

  assert_keep_lead_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && keep_lead_i |=> !line_drop_o);

  assert_no_late_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i && ((eol_i && line_yc_o) || !line_drop_o) |=> !line_drop_o);

  assert_yonly_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pack_mode_o == 3'd4 |-> !line_yc_o && !line_drop_o);

  assert_code_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pack_mode_o <= 3'd4);

  assert_reserved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && pack_sel_i > 3'd4 |=> pack_mode_o == 3'd0);

endmodule

bind line_fmt_seq line_fmt_seq_chk #(.CadW(CadW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sof_i       (sof_i),
  .eol_i       (eol_i),
  .cadence_i   (cadence_i),
  .keep_lead_i (keep_lead_i),
  .pack_sel_i  (pack_sel_i),
  .line_yc_o   (line_yc_o),
  .line_drop_o (line_drop_o),
  .pack_mode_o (pack_mode_o)
);

// File: tb/test_line_fmt_seq.sv
module test_line_fmt_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, eol = 1'b0, keep = 1'b0;
  logic [1:0] cad = '0;
  logic [2:0] sel = '0;
  logic       yc, drop;
  logic [2:0] mode;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  line_fmt_seq i_line_fmt_seq (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .eol_i(eol),
    .cadence_i(cad), .keep_lead_i(keep), .pack_sel_i(sel),
    .line_yc_o(yc), .line_drop_o(drop), .pack_mode_o(mode)
  );

  // {op(1 sof,2 eol,3 both,0 idle), cad, keep, sel, exp_yc, exp_drop, exp_mode, req}
  localparam int NV = 23;
  localparam logic [16:0] VEC [NV] = '{
    {2'd1, 2'd2, 1'b0, 3'd2, 1'b0, 1'b1, 3'd2, 4'd6},  // R6 lead drop
    {2'd2, 2'd0, 1'b1, 3'd0, 1'b0, 1'b1, 3'd2, 4'd2},  // R2 mid-field cfg ignored
    {2'd2, 2'd0, 1'b1, 3'd0, 1'b1, 1'b0, 3'd2, 4'd4},  // R4
    {2'd2, 2'd0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd2, 4'd8},  // R8
    {2'd2, 2'd0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd2, 4'd8},  // R8
    {2'd2, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd2, 4'd4},  // R4
    {2'd0, 2'd1, 1'b0, 3'd1, 1'b1, 1'b0, 3'd2, 4'd4},  // R4 idle holds
    {2'd1, 2'd2, 1'b1, 3'd3, 1'b0, 1'b0, 3'd3, 4'd7},  // R7
    {2'd2, 2'd2, 1'b1, 3'd3, 1'b0, 1'b0, 3'd3, 4'd7},  // R7
    {2'd2, 2'd2, 1'b1, 3'd3, 1'b1, 1'b0, 3'd3, 4'd4},  // R4
    {2'd1, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 4'd5},  // R5
    {2'd2, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 4'd5},  // R5
    {2'd2, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 4'd5},  // R5
    {2'd1, 2'd3, 1'b0, 3'd4, 1'b0, 1'b0, 3'd4, 4'd9},  // R9
    {2'd2, 2'd3, 1'b0, 3'd4, 1'b0, 1'b0, 3'd4, 4'd9},  // R9
    {2'd1, 2'd1, 1'b0, 3'd6, 1'b0, 1'b1, 3'd0, 4'd10}, // R10 reserved
    {2'd2, 2'd1, 1'b0, 3'd6, 1'b1, 1'b0, 3'd0, 4'd4},  // R4
    {2'd3, 2'd3, 1'b0, 3'd1, 1'b0, 1'b1, 3'd1, 4'd11}, // R11 sof wins
    {2'd2, 2'd3, 1'b0, 3'd1, 1'b0, 1'b1, 3'd1, 4'd6},  // R6
    {2'd2, 2'd3, 1'b0, 3'd1, 1'b0, 1'b1, 3'd1, 4'd6},  // R6
    {2'd2, 2'd3, 1'b0, 3'd1, 1'b1, 1'b0, 3'd1, 4'd4},  // R4
    {2'd1, 2'd3, 1'b0, 3'd1, 1'b0, 1'b1, 3'd1, 4'd3},  // R3 restart mid cadence
    {2'd1, 2'd0, 1'b0, 3'd7, 1'b1, 1'b0, 3'd0, 4'd10}  // R10 reserved
  };

  task automatic check(input int req, input logic eyc, input logic edr, input logic [2:0] em);
    n_chk++;
    if (yc !== eyc || drop !== edr || mode !== em) begin
      n_bad++;
      $display("FAIL R%0d: yc/drop/mode got %b/%b/%0d exp %b/%b/%0d",
               req, yc, drop, mode, eyc, edr, em);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hang exp finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b1, 1'b0, 3'd0);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    eol = 1'b1; cad = 2'd3; sel = 3'd2;
    @(negedge clk);
    eol = 1'b0;
    check(1, 1'b1, 1'b0, 3'd0);  // R1 no sof yet: defaults hold

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v    = VEC[i];
      sof  = v[15];
      eol  = v[16];
      cad  = v[14:13];
      keep = v[12];
      sel  = v[11:9];
      @(negedge clk);
      sof = 1'b0; eol = 1'b0;
      check(int'(v[3:0]), v[8], v[7], v[6:4]);
    end

    // R1 asynchronous reset mid-field
    sof = 1'b1; cad = 2'd2; keep = 1'b0; sel = 3'd2;
    @(negedge clk);
    sof = 1'b0;
    check(6, 1'b0, 1'b1, 3'd2);
    #2 rst_n = 1'b0;
    #1 check(1, 1'b1, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule